// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends bytes on a single serial line as asynchronous frames. A one-entry holding stage sits in front of a frame shifter, so software can queue the next byte while the current one is still going out. The line rests at 1. Each frame is a 0 start bit, then the data bits least significant first, then an optional ninth bit, then a 1 stop bit.

A write strobe captures the byte and, in the same cycle, the level of a separate ninth-bit input. That input must therefore be set up before the byte is written. When the shifter is free and the holding stage is full, the byte moves across. Its start bit begins on the next cycle, and a queued byte follows a finished stop bit with no idle gap.

The bit period comes from the system clock divided by 16·(N+1) or 64·(N+1). A speed-select input picks the factor and N is a divisor input. Two flags are visible to software: one shows that the holding stage is empty, the other that the shifter is empty. Dropping the enable input abandons any frame in progress and empties both stages.

Top module: `serial_tx_dbuf`

## Requirements
- R1: While `rst` is 1, and on the cycle after it, `txd` is 1 and both `hold_empty` and `shift_empty` are 1.
- R2: The line idles at 1 whenever `shift_empty` is 1. A frame is a 0 start bit, then `wr_data` bit 0 up to bit 7, then the optional ninth bit, then a 1 stop bit.
- R3: Every bit of a frame lasts exactly 16·(N+1) clock cycles when `fast_sel` is 1 and 64·(N+1) cycles when `fast_sel` is 0, where N is the value on `divisor`.
- R4: When `nine_bit` is 1, the value of `bit9_in` captured in the write cycle is sent after data bit 7, giving an 11-bit frame. When `nine_bit` is 0 the frame is 10 bits and `bit9_in` has no effect.
- R5: A write (`wr_valid` = 1) with `tx_en` = 1 and `hold_empty` = 1 is taken. `hold_empty` reads 0 on the following cycle. If the shifter is idle, the start bit appears one cycle after that and `hold_empty` returns to 1.
- R6: A write while `tx_en` is 0 is ignored: `hold_empty` stays 1 and no frame is sent, even after `tx_en` returns to 1.
- R7: If a byte is waiting when a stop bit ends, its start bit begins on the very next cycle with no idle bit, and `hold_empty` rises in that same cycle.
- R8: A write while `hold_empty` is 0 is ignored. The waiting byte and its ninth bit are kept, and the rejected byte is never sent.
- R9: When `tx_en` is 0 at a clock edge, `txd`, `hold_empty` and `shift_empty` all read 1 after that edge. Any queued byte is discarded.
- R10: `shift_empty` falls in the same cycle as the start bit begins. It rises once the last stop bit has lasted a full bit period and nothing is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable; 0 aborts and empties both stages |
| nine_bit | input | 1 | 1 = 11-bit frames with ninth bit, 0 = 10-bit frames |
| fast_sel | input | 1 | 1 = bit period 16·(N+1) clocks, 0 = 64·(N+1) clocks |
| divisor | input | DIV_W | Divisor N for the bit period |
| wr_valid | input | 1 | Write strobe for the holding stage |
| wr_data | input | DATA_W | Byte to send |
| bit9_in | input | 1 | Ninth bit, captured with the byte on a write |
| txd | output | 1 | Serial output line, idles at 1 |
| hold_empty | output | 1 | Holding stage can accept a write |
| shift_empty | output | 1 | No frame is being sent |

## Verification
Some relations hold on every cycle, and the assertions check those: the reset and disable states of the line and both flags, the line being high whenever the shifter is empty, an accepted write clearing the holding flag, and a frame starting with a 0 bit. The bench scenarios show what a cycle-by-cycle property cannot. These are the exact bit length for each speed and divisor, the order of the bits and the ninth-bit value, back-to-back frames with no gap, and whether a rejected or aborted byte is ever sent later.

// File: rtl/uatx_pkg.sv
package uatx_pkg;

  // Bit-period prescale factors, stored as left-shift amounts.
  localparam int unsigned HI_SHIFT = 4;  // x16
  localparam int unsigned LO_SHIFT = 6;  // x64

  // Frame length selection
  typedef enum logic {
    FRM_8BIT = 1'b0,
    FRM_9BIT = 1'b1
  } frame_mode_e;

  // Extra bits around the data: start, ninth and stop
  localparam int unsigned FRAME_EXTRA = 3;

endpackage

// File: rtl/uatx_baud.sv
module uatx_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             fast,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  localparam int CNT_W = DIV_W + int'(uatx_pkg::LO_SHIFT) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] last_cnt;

  // The period is (N+1) shifted by the selected prescale, minus one for the terminal count.
  always_comb begin
    span     = CNT_W'(divisor) + CNT_W'(1);
    last_cnt = (fast ? (span << uatx_pkg::HI_SHIFT)
                     : (span << uatx_pkg::LO_SHIFT)) - CNT_W'(1);
  end

  assign tick = run && (cnt_q == last_cnt);

  // The counter is held at zero while idle, so every frame starts with a full period.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == last_cnt) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/uatx_hold.sv
module uatx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  input  logic              take,
  output logic              empty,
  output logic [DATA_W-1:0] data,
  output logic              bit9
);
  logic accept;

  assign accept = en && wr && empty;

  // Occupancy flag: reset or disable empties the stage; take has priority over a write.
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      empty <= 1'b1;
    end else if (take) begin
      empty <= 1'b1;
    end else if (accept) begin
      empty <= 1'b0;
    end
  end

  // Payload registers carry no reset; they are read only while the stage is full.
  always_ff @(posedge clk) begin
    if (accept) begin
      data <= wr_data;
      bit9 <= wr_bit9;
    end
  end

endmodule

// File: rtl/uatx_shift.sv
module uatx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              nine_mode,
  input  logic              tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              hold_bit9,
  output logic              take,
  output logic              txd,
  output logic              idle
);
  localparam int FRAME_W = DATA_W + int'(uatx_pkg::FRAME_EXTRA);
  localparam int IDX_W   = $clog2(FRAME_W);
  localparam logic [IDX_W-1:0] LAST_9 = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] LAST_8 = IDX_W'(FRAME_W - 2);

  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] frame_new;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   last_q;
  logic [IDX_W-1:0]   idx_nxt;
  logic               at_end;
  logic               is_nine;

  assign is_nine = (nine_mode == uatx_pkg::FRM_9BIT);

  // Frame from bit 0 upward: start 0, data LSB first, ninth bit or stop pad, stop 1.
  assign frame_new = {1'b1, (is_nine ? hold_bit9 : 1'b1), hold_data, 1'b0};

  assign idx_nxt = idx_q + IDX_W'(1);
  assign at_end  = !idle && tick && (idx_q == last_q);
  assign take    = hold_full && (idle || at_end);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      idle    <= 1'b1;
      txd     <= 1'b1;
      idx_q   <= '0;
      last_q  <= '0;
      frame_q <= '1;
    end else if (take) begin
      idle    <= 1'b0;
      txd     <= 1'b0;
      idx_q   <= '0;
      frame_q <= frame_new;
      last_q  <= is_nine ? LAST_9 : LAST_8;
    end else if (at_end) begin
      idle    <= 1'b1;
      txd     <= 1'b1;
      idx_q   <= '0;
    end else if (!idle && tick) begin
      idx_q   <= idx_nxt;
      txd     <= frame_q[idx_nxt];
    end
  end

endmodule

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              nine_bit,
  input  logic              fast_sel,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit9_in,
  output logic              txd,
  output logic              hold_empty,
  output logic              shift_empty
);
  logic              take;
  logic              tick;
  logic [DATA_W-1:0] hold_data;
  logic              hold_bit9;

  uatx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .en      (tx_en),
    .wr      (wr_valid),
    .wr_data (wr_data),
    .wr_bit9 (bit9_in),
    .take    (take),
    .empty   (hold_empty),
    .data    (hold_data),
    .bit9    (hold_bit9)
  );

  uatx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst     (rst),
    .run     (!shift_empty),
    .fast    (fast_sel),
    .divisor (divisor),
    .tick    (tick)
  );

  uatx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .en        (tx_en),
    .nine_mode (nine_bit),
    .tick      (tick),
    .hold_full (!hold_empty),
    .hold_data (hold_data),
    .hold_bit9 (hold_bit9),
    .take      (take),
    .txd       (txd),
    .idle      (shift_empty)
  );

endmodule

// File: rtl/serial_tx_dbuf_chk.sv
module serial_tx_dbuf_chk (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic wr_valid,
  input logic txd,
  input logic hold_empty,
  input logic shift_empty
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (txd && hold_empty && shift_empty));

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    shift_empty |-> txd);

  // R5
  write_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_en && hold_empty && wr_valid) |=> !hold_empty);

  // R9
  disable_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (txd && hold_empty && shift_empty));

  // R10
  start_low_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(shift_empty) |-> !txd);

endmodule

bind serial_tx_dbuf serial_tx_dbuf_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .tx_en       (tx_en),
  .wr_valid    (wr_valid),
  .txd         (txd),
  .hold_empty  (hold_empty),
  .shift_empty (shift_empty)
);

// File: tb/tb_serial_tx_dbuf.sv
`timescale 1ns/1ps
module tb_serial_tx_dbuf;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0;
  logic       nine_bit = 1'b0;
  logic       fast_sel = 1'b1;
  logic [7:0] divisor = 8'd0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       bit9_in = 1'b0;
  logic       txd, hold_empty, shift_empty;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  serial_tx_dbuf dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .nine_bit(nine_bit),
    .fast_sel(fast_sel), .divisor(divisor), .wr_valid(wr_valid),
    .wr_data(wr_data), .bit9_in(bit9_in), .txd(txd),
    .hold_empty(hold_empty), .shift_empty(shift_empty)
  );

  // {nine_bit, fast_sel, divisor[7:0], bit9, data[7:0]}
  localparam logic [18:0] VECS [6] = '{
    {1'b0, 1'b1, 8'd0, 1'b0, 8'hA5},
    {1'b1, 1'b1, 8'd0, 1'b1, 8'h3C},
    {1'b1, 1'b0, 8'd0, 1'b0, 8'h81},
    {1'b0, 1'b0, 8'd1, 1'b1, 8'h5A},
    {1'b1, 1'b1, 8'd2, 1'b0, 8'hFF},
    {1'b0, 1'b1, 8'd3, 1'b0, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d, input logic b9);
    wr_valid = 1'b1;
    wr_data  = d;
    bit9_in  = b9;
    tick_n(1);
    wr_valid = 1'b0;
  endtask

  function automatic logic [10:0] exp_frame(input logic nine, input logic [7:0] d, input logic b9);
    return {1'b1, (nine ? b9 : 1'b1), d, 1'b0};
  endfunction

  // Called at the falling edge in the first cycle of a start bit.
  task automatic check_frame(input logic [10:0] f, input int nbits, input int per);
    for (int i = 0; i < nbits; i++) begin
      chk("R2/R4 bit value at bit start", txd, f[i]);
      chk("R10 shifter busy during frame", shift_empty, 1'b0);
      tick_n(per - 1);
      chk("R3 bit value at bit end", txd, f[i]);
      tick_n(1);
    end
    chk("R10 shifter empty after stop", shift_empty, 1'b1);
    chk("R2 line idles high", txd, 1'b1);
  endtask

  initial begin
    // R1: reset state, with enable already high
    tx_en = 1'b1;
    @(negedge clk);
    chk("R1 txd in reset", txd, 1'b1);
    tick_n(2);
    chk("R1 hold_empty in reset", hold_empty, 1'b1);
    chk("R1 shift_empty in reset", shift_empty, 1'b1);
    rst = 1'b0;
    tick_n(1);
    chk("R1 txd after reset", txd, 1'b1);

    // Table walk: R2, R3, R4, R5
    for (int v = 0; v < 6; v++) begin
      logic [18:0] e;
      int per;
      e = VECS[v];
      nine_bit = e[18];
      fast_sel = e[17];
      divisor  = e[16:9];
      per = (int'(e[16:9]) + 1) * (e[17] ? 16 : 64);
      do_write(e[7:0], e[8]);
      chk("R5 hold_empty low after write", hold_empty, 1'b0);
      chk("R5 line still idle one cycle after write", txd, 1'b1);
      tick_n(1);
      chk("R5 hold_empty back high at transfer", hold_empty, 1'b1);
      check_frame(exp_frame(e[18], e[7:0], e[8]), e[18] ? 11 : 10, per);
    end

    // Back-to-back frames, ninth-bit capture, write while full: R7, R4, R8
    nine_bit = 1'b1; fast_sel = 1'b1; divisor = 8'd0;
    do_write(8'h96, 1'b0);
    tick_n(1);                       // t=0, start bit of the first frame
    chk("R2 start bit low", txd, 1'b0);
    do_write(8'h4B, 1'b1);           // t=1
    chk("R5 second byte queued", hold_empty, 1'b0);
    do_write(8'hE7, 1'b0);           // t=2, rejected, ninth-bit input now 0
    chk("R8 holding stays full", hold_empty, 1'b0);
    tick_n(173);                     // t=175, last stop-bit cycle
    chk("R2 stop bit of first frame", txd, 1'b1);
    chk("R7 byte still waiting", hold_empty, 1'b0);
    tick_n(1);                       // t=176
    chk("R7 next start bit with no gap", txd, 1'b0);
    chk("R7 hold_empty rises at transfer", hold_empty, 1'b1);
    chk("R7 shifter stays busy", shift_empty, 1'b0);
    check_frame(exp_frame(1'b1, 8'h4B, 1'b1), 11, 16);
    tick_n(300);
    chk("R8 rejected byte never sent (line)", txd, 1'b1);
    chk("R8 rejected byte never sent (shifter)", shift_empty, 1'b1);

    // Abort mid-frame: R9
    nine_bit = 1'b0;
    do_write(8'h00, 1'b0);
    tick_n(1);                       // t=0
    do_write(8'hCC, 1'b0);           // t=1
    tick_n(39);                      // t=40, data bit 1 = 0
    chk("R9 line low before abort", txd, 1'b0);
    tx_en = 1'b0;
    tick_n(1);
    chk("R9 txd high after abort", txd, 1'b1);
    chk("R9 hold_empty after abort", hold_empty, 1'b1);
    chk("R9 shift_empty after abort", shift_empty, 1'b1);
    tx_en = 1'b1;
    tick_n(200);
    chk("R9 queued byte discarded", shift_empty, 1'b1);
    chk("R9 line stays idle", txd, 1'b1);

    // Write while disabled: R6
    tx_en = 1'b0;
    do_write(8'h0F, 1'b0);
    chk("R6 write ignored when disabled", hold_empty, 1'b1);
    tick_n(50);
    chk("R6 no frame while disabled", shift_empty, 1'b1);
    tx_en = 1'b1;
    tick_n(50);
    chk("R6 no frame after re-enable", txd, 1'b1);
    chk("R6 shifter idle after re-enable", shift_empty, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule